// File: doc/BRIEF.md
# UART Receive Queue with Level Interrupt

This block is the receive-side character store of a serial port. The deserialiser delivers characters through a push port. Each character comes with four line-error flags. The queue keeps the characters in arrival order until software removes them through a data-register read, which appears to the block as a one-cycle pop strobe. A mode input switches the queue at run time between two modes. In queue mode it holds up to `DEPTH` entries. In single-character mode it acts as a one-entry holding register. Every change of the mode input throws away whatever is stored.

Each stored entry is 12 bits wide: the character sits in the low byte and the error flags sit above it. When an entry is popped, its error flags are copied into a separate status register, and a write strobe to that register clears it. A receive interrupt request is set when a push brings the fill count exactly to `TRIG_LEVEL`. It is withdrawn by the pop after which the count plus one equals that level. A detected line break is stored as its own entry carrying only the break flag.

Occupancy is tracked by a three-state machine. The states are OCC_EMPTY (nothing stored), OCC_PART (some entries stored but free room left) and OCC_FULL (count equals the active depth). The transitions are:
- fill: OCC_EMPTY to OCC_PART, on a push in queue mode.
- fill_last: OCC_EMPTY or OCC_PART to OCC_FULL, on the push that reaches the active depth.
- drain_last: OCC_PART or OCC_FULL to OCC_EMPTY, on the pop that removes the last entry.
- drain: OCC_FULL to OCC_PART, on a pop that leaves entries behind.
- flush: any state to OCC_EMPTY, on a mode change or a soft reset.

Top module: `uart_rx_queue`

## Requirements
- R1: `rd_entry` shows the entry at the current read position combinationally. Bits 7:0 hold the character. Bit 8 is framing, bit 9 parity, bit 10 break and bit 11 overrun. Bits 11:8 are taken from `push_err[3:0]` in the same order.
- R2: With `fifo_en`=1 the queue holds 16 entries and returns them in push order. `full` rises on the 16th stored entry. `empty` is 1 exactly when nothing is stored.
- R3: With `fifo_en`=0 the queue holds one entry, so `full` rises after a single push.
- R4: A push while the count equals the active depth is dropped. The stored entries and the read position are left unchanged.
- R5: A pop while empty leaves the count and the read position unchanged. Its status copy still takes the error bits of the entry shown at the read position.
- R6: Any cycle in which `fifo_en` differs from the mode in effect empties the queue: `empty`=1, `full`=0, read position 0. A push or pop in that cycle is ignored, and `rx_irq` keeps its value.
- R7: A push that makes the count equal `TRIG_LEVEL` sets `rx_irq`.
- R8: A pop sets `rx_irq` to 0 when the count after the pop, plus one, equals `TRIG_LEVEL`. This includes a pop on an empty queue when `TRIG_LEVEL` is 1.
- R9: Every accepted pop loads `rx_status` with bits 11:8 of the popped entry. This takes priority over `status_clr` in the same cycle.
- R10: `status_clr` without a pop sets `rx_status` to 0.
- R11: `line_break` pushes the entry 12'h400 (only the break flag set), overriding `push_char`/`push_err`.
- R12: After `rst_n` low or a `soft_rst` cycle: `empty`=1, `full`=0, `rx_irq`=0, `rx_status`=0, single-character mode in effect, stored entries zero.
- R13: A push and a pop in the same cycle act as the pop first, then the push against the count left by the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous reset of the whole queue |
| fifo_en | input | 1 | 1 = queue mode (DEPTH entries), 0 = single-character mode |
| push_valid | input | 1 | Store one received character this cycle |
| push_char | input | 8 | Received character |
| push_err | input | 4 | Error flags {overrun, break, parity, framing} |
| line_break | input | 1 | Store a break entry this cycle |
| pop | input | 1 | Data-register read: remove the shown entry |
| status_clr | input | 1 | Write to the status register: clear it |
| rd_entry | output | 12 | Entry at the read position |
| empty | output | 1 | No entries stored |
| full | output | 1 | Count equals active depth |
| rx_status | output | 4 | Error flags of the last popped entry |
| rx_irq | output | 1 | Receive level interrupt request |

## Verification
The bench targets the following corner cases, with the failure each one would expose:
- The full/drop boundary in both depths. A design that wraps instead of dropping would overwrite the oldest character and shift the output order.
- Pops on an empty queue. A design that advances the read pointer there would return the wrong character on the next read, and the status copy of the stale entry would also differ.
- Mode flips with a pending interrupt and a push in the same cycle. A design that clears the request or stores that push would leave a false request or a phantom character.
- Simultaneous push and pop at counts 0, 1 and 16. A wrong ordering shows up as a wrongly dropped push, or as a request left set after the pop that should withdraw it.
- A long pseudo-random run in both modes, compared against an arithmetic model. This catches slot-index and wrap errors.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int CHAR_W  = 8;
    localparam int ERR_W   = 4;
    localparam int ENTRY_W = CHAR_W + ERR_W;

    // Stored entry: overrun at bit 11 down to framing at bit 8, character below.
    typedef struct packed {
        logic              ovr;
        logic              brk;
        logic              par;
        logic              frm;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    localparam logic [ENTRY_W-1:0] BREAK_ENTRY = 12'h400;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [W-1:0]             rd_data
);
    localparam int PW = $clog2(DEPTH);

    logic [DEPTH-1:0][W-1:0] slot_bus;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (clr) begin
                q <= '0;
            end else if (wr_en && (wr_addr == PW'(i))) begin
                q <= wr_data;
            end
        end
        assign slot_bus[i] = q;
    end

    assign rd_data = slot_bus[rd_addr];

endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     fifo_en,
    input  logic                     push_req,
    input  logic                     pop_req,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_slot,
    output logic [$clog2(DEPTH)-1:0] rd_pos,
    output logic                     pop_take,
    output logic                     empty,
    output logic                     full,
    output logic                     irq
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    occ_state_t    state_q, state_n;
    logic          mode_q;
    logic [PW-1:0] pos_q, pos_a, mask;
    logic [CW-1:0] cnt_q, cnt_a, cnt_n, cap;
    logic          irq_q, irq_n;
    logic          mode_chg, pop_move, push_take;

    // Datapath for the effective depth, pop-then-push ordering and interrupt level
    always_comb begin
        mode_chg  = (fifo_en != mode_q);
        cap       = mode_q ? CW'(DEPTH) : CW'(1);
        mask      = mode_q ? PW'(DEPTH - 1) : '0;
        pop_take  = pop_req & ~mode_chg & ~soft_rst;
        pop_move  = pop_take & (cnt_q != '0);
        cnt_a     = pop_move ? cnt_q - CW'(1) : cnt_q;
        pos_a     = pop_move ? ((pos_q + PW'(1)) & mask) : pos_q;
        push_take = push_req & ~mode_chg & ~soft_rst & (cnt_a < cap);
        wr_slot   = (pos_a + cnt_a[PW-1:0]) & mask;
        cnt_n     = cnt_a + CW'(push_take);
        irq_n     = irq_q;
        if (pop_take && ((cnt_a + CW'(1)) == CW'(TRIG))) begin
            irq_n = 1'b0;
        end
        if (push_take && (cnt_n == CW'(TRIG))) begin
            irq_n = 1'b1;
        end
    end

    assign wr_en  = push_take;
    assign rd_pos = pos_q;
    assign irq    = irq_q;

    // Occupancy next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push_take) begin
                    state_n = (cnt_n == cap) ? OCC_FULL : OCC_PART;
                end
            end
            OCC_PART: begin
                if (cnt_n == '0) begin
                    state_n = OCC_EMPTY;
                end else if (cnt_n == cap) begin
                    state_n = OCC_FULL;
                end
            end
            OCC_FULL: begin
                if (cnt_n != cap) begin
                    state_n = (cnt_n == '0) ? OCC_EMPTY : OCC_PART;
                end
            end
            default: state_n = OCC_EMPTY;
        endcase
        if (mode_chg || soft_rst) begin
            state_n = OCC_EMPTY;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_n;
        end
    end

    // Pointer, count, mode and interrupt registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            pos_q  <= '0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else if (soft_rst) begin
            mode_q <= 1'b0;
            pos_q  <= '0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else if (mode_chg) begin
            mode_q <= fifo_en;
            pos_q  <= '0;
            cnt_q  <= '0;
        end else begin
            pos_q  <= pos_a;
            cnt_q  <= cnt_n;
            irq_q  <= irq_n;
        end
    end

    // Flag outputs from the occupancy state
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY: empty = 1'b1;
            OCC_PART:  ;
            OCC_FULL:  full = 1'b1;
            default:   empty = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_rxq_status.sv
module uart_rxq_status
    import uart_rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             pop_take,
    input  logic             clr,
    input  logic [ERR_W-1:0] err_in,
    output logic [ERR_W-1:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (soft_rst) begin
            status <= '0;
        end else if (pop_take) begin
            status <= err_in;
        end else if (clr) begin
            status <= '0;
        end
    end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int TRIG_LEVEL = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        fifo_en,
    input  logic        push_valid,
    input  logic [7:0]  push_char,
    input  logic [3:0]  push_err,
    input  logic        line_break,
    input  logic        pop,
    input  logic        status_clr,
    output logic [11:0] rd_entry,
    output logic        empty,
    output logic        full,
    output logic [3:0]  rx_status,
    output logic        rx_irq
);
    localparam int PW = $clog2(DEPTH);

    rxq_entry_t    in_entry, out_entry;
    logic          wr_en, pop_take;
    logic [PW-1:0] wr_slot, rd_pos;

    assign in_entry  = line_break ? rxq_entry_t'(BREAK_ENTRY)
                                  : rxq_entry_t'({push_err, push_char});
    assign rd_entry  = out_entry;

    uart_rxq_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG_LEVEL)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .fifo_en  (fifo_en),
        .push_req (push_valid | line_break),
        .pop_req  (pop),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .rd_pos   (rd_pos),
        .pop_take (pop_take),
        .empty    (empty),
        .full     (full),
        .irq      (rx_irq)
    );

    uart_rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .wr_en   (wr_en),
        .wr_addr (wr_slot),
        .wr_data (in_entry),
        .rd_addr (rd_pos),
        .rd_data (out_entry)
    );

    uart_rxq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .pop_take (pop_take),
        .clr      (status_clr),
        .err_in   ({out_entry.ovr, out_entry.brk, out_entry.par, out_entry.frm}),
        .status   (rx_status)
    );

endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
    parameter int TRIG = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        fifo_en,
    input logic        push_valid,
    input logic        line_break,
    input logic        pop,
    input logic        status_clr,
    input logic [11:0] rd_entry,
    input logic        empty,
    input logic        full,
    input logic [3:0]  rx_status,
    input logic        rx_irq
);
    logic mode_seen;
    logic quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_seen <= 1'b0;
        end else if (soft_rst) begin
            mode_seen <= 1'b0;
        end else begin
            mode_seen <= fifo_en;
        end
    end

    assign quiet = !soft_rst && (fifo_en == mode_seen);

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && full && push_valid && !pop) |=> (full && $stable(rd_entry)));

    a_r6_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && fifo_en != mode_seen) |=> (empty && !full && $stable(rx_irq)));

    a_r7_irq_on_first: assert property (@(posedge clk) disable iff (!rst_n)
        (TRIG == 1 && quiet && empty && (push_valid || line_break) && !pop) |=> rx_irq);

    a_r8_irq_drop_on_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (TRIG == 1 && quiet && empty && pop && !push_valid && !line_break) |=> !rx_irq);

    a_r9_status_from_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && pop) |=> (rx_status == $past(rd_entry[11:8])));

    a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !pop) |=> (rx_status == 4'h0));

    a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (empty && !full && !rx_irq && rx_status == 4'h0));

endmodule

bind uart_rx_queue uart_rx_queue_chk #(.TRIG(TRIG_LEVEL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .fifo_en    (fifo_en),
    .push_valid (push_valid),
    .line_break (line_break),
    .pop        (pop),
    .status_clr (status_clr),
    .rd_entry   (rd_entry),
    .empty      (empty),
    .full       (full),
    .rx_status  (rx_status),
    .rx_irq     (rx_irq)
);

// File: tb/tb_uart_rx_queue.sv
`timescale 1ns/1ps
module tb_uart_rx_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        fifo_en = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_char = '0;
    logic [3:0]  push_err = '0;
    logic        line_break = 1'b0;
    logic        pop = 1'b0;
    logic        status_clr = 1'b0;
    logic [11:0] rd_entry;
    logic        empty, full, rx_irq;
    logic [3:0]  rx_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model
    logic [11:0] m [16];
    int          mpos, mcnt;
    bit          mmode, mirq;
    logic [3:0]  mstat;

    always #2 clk = ~clk;

    uart_rx_queue #(.DEPTH(16), .TRIG_LEVEL(1)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fifo_en(fifo_en),
        .push_valid(push_valid), .push_char(push_char), .push_err(push_err),
        .line_break(line_break), .pop(pop), .status_clr(status_clr),
        .rd_entry(rd_entry), .empty(empty), .full(full),
        .rx_status(rx_status), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m[i] = '0;
        mpos = 0; mcnt = 0; mmode = 1'b0; mirq = 1'b0; mstat = '0;
    endtask

    task automatic check_all(input string tag);
        int dep;
        dep = mmode ? 16 : 1;
        chk(tag, "empty", {11'd0, empty}, {11'd0, mcnt == 0});
        chk(tag, "full", {11'd0, full}, {11'd0, mcnt == dep});
        chk(tag, "rx_irq", {11'd0, rx_irq}, {11'd0, mirq});
        chk(tag, "rx_status", {8'd0, rx_status}, {8'd0, mstat});
        chk(tag, "rd_entry", rd_entry, m[mpos]);
    endtask

    // One cycle: drive at the falling edge, check the shown entry, update model, check after the edge
    task automatic cyc(input logic pv, input logic [7:0] ch, input logic [3:0] er,
                       input logic lb, input logic pp, input logic en,
                       input logic cl, input logic sr, input string tag);
        int dep;
        logic [11:0] ent;
        push_valid = pv; push_char = ch; push_err = er; line_break = lb;
        pop = pp; fifo_en = en; status_clr = cl; soft_rst = sr;
        #1;
        chk(tag, "rd_entry before edge", rd_entry, m[mpos]);   // R1 combinational view
        ent = lb ? 12'h400 : {er, ch};
        if (sr) begin
            model_reset();
        end else if (en != mmode) begin
            mcnt = 0; mpos = 0; mmode = en;
            if (cl) mstat = '0;
        end else begin
            dep = mmode ? 16 : 1;
            if (pp) begin
                mstat = m[mpos][11:8];
                if (mcnt > 0) begin
                    mcnt--;
                    mpos = (mpos + 1) % dep;
                end
                if (mcnt + 1 == 1) mirq = 1'b0;
            end else if (cl) begin
                mstat = '0;
            end
            if ((pv || lb) && mcnt < dep) begin
                m[(mpos + mcnt) % dep] = ent;
                mcnt++;
                if (mcnt == 1) mirq = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        check_all(tag);
        @(negedge clk);
    endtask

    logic cur_en = 1'b0;

    task automatic push(input logic [7:0] ch, input logic [3:0] er, input string tag);
        cyc(1'b1, ch, er, 1'b0, 1'b0, cur_en, 1'b0, 1'b0, tag);
    endtask
    task automatic pull(input string tag);
        cyc(1'b0, 8'h00, 4'h0, 1'b0, 1'b1, cur_en, 1'b0, 1'b0, tag);
    endtask
    task automatic idle(input string tag);
        cyc(1'b0, 8'h00, 4'h0, 1'b0, 1'b0, cur_en, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R12");                          // reset state
        idle("R12");

        // R3 single-character mode, R7 request on first push
        push(8'h5A, 4'b0001, "R3");
        push(8'h33, 4'b0000, "R4");                // dropped while full
        pull("R1");                                // 0x15A out, R8 request withdrawn
        pull("R5");                                // empty pop, stale status copy

        // R6 switch to queue mode
        cur_en = 1'b1;
        idle("R6");
        for (int i = 0; i < 16; i++) push(8'(i * 13 + 7), 4'(i), "R2");
        push(8'hEE, 4'hF, "R4");
        for (int i = 0; i < 16; i++) pull("R9");
        pull("R5");
        pull("R8");

        // R13 simultaneous push and pop at several counts
        cyc(1'b1, 8'hA1, 4'h2, 1'b0, 1'b1, cur_en, 1'b0, 1'b0, "R13");  // count 0
        cyc(1'b1, 8'hA2, 4'h4, 1'b0, 1'b1, cur_en, 1'b0, 1'b0, "R13");  // count 1
        for (int i = 0; i < 15; i++) push(8'(i), 4'h0, "R13");
        cyc(1'b1, 8'hA3, 4'h8, 1'b0, 1'b1, cur_en, 1'b0, 1'b0, "R13");  // count 16
        for (int i = 0; i < 16; i++) pull("R13");

        // R11 line break overrides push data
        cyc(1'b1, 8'h77, 4'h3, 1'b1, 1'b0, cur_en, 1'b0, 1'b0, "R11");
        pull("R11");

        // R10 clear, R9 pop beats clear
        push(8'h10, 4'hF, "R10");
        pull("R10");
        cyc(1'b0, 8'h00, 4'h0, 1'b0, 1'b0, cur_en, 1'b1, 1'b0, "R10");
        push(8'h20, 4'hA, "R9");
        cyc(1'b0, 8'h00, 4'h0, 1'b0, 1'b1, cur_en, 1'b1, 1'b0, "R9");

        // R6 flush keeps a pending request and ignores push/pop in that cycle
        push(8'h30, 4'h1, "R7");
        push(8'h31, 4'h2, "R7");
        cur_en = 1'b0;
        cyc(1'b1, 8'h99, 4'h5, 1'b0, 1'b1, cur_en, 1'b0, 1'b0, "R6");
        idle("R6");

        // R12 soft reset
        push(8'h44, 4'h6, "R12");
        cyc(1'b0, 8'h00, 4'h0, 1'b0, 1'b0, cur_en, 1'b0, 1'b1, "R12");
        idle("R12");

        // Pseudo-random sweep over both modes
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 150 == 40) cur_en = ~cur_en;
            cyc(lfsr[0] | lfsr[1], lfsr[9:2], lfsr[13:10], (lfsr[15:11] == 5'h1F),
                lfsr[2] & lfsr[5], cur_en, (lfsr[7:4] == 4'h0),
                (n == 333), "R13");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule